// File: doc/BRIEF.md
# Block Transfer Engine with Bus Hand-off

This block moves a block of words between a peripheral and memory without the processor touching each word. The processor loads a start address, a word count and a mode word through a small register port, but only while it still owns the bus, which it shows by holding bus grant low. The mode word picks the direction (memory read or memory write) and how long the engine holds the bus. It also carries a start bit.

Once the engine is armed, a request from the peripheral makes it ask the processor for the bus. When grant arrives, it puts its address register on the memory address lines, strobes memory read or memory write, and acknowledges the peripheral. Each completed word advances the address and reduces the count. In burst tenure the engine keeps the bus for as long as the peripheral keeps requesting. In cycle-steal tenure it gives the bus back after every word. When the count reaches zero it drops its bus request and raises an interrupt. The interrupt stays up until the processor writes the mode word.

Top module: `dma_engine`

## Requirements
- R1: After reset, bus_req, mem_rd, mem_wr, dev_ack and irq are low, and the address and count registers read zero.
- R2: With cs high and bus_grant low, rsel selects a register: 0 is the start address, 1 is the word count, 2 is the mode word. A write strobe loads the selected register. A read returns it, with mode bits {bit3 busy (read-only), bit2 burst, bit1 to-memory, bit0 start (reads 0)}.
- R3: While bus_grant is high, register writes, including the start bit, are ignored and rdata reads zero.
- R4: After start, bus_req stays low until dev_req is high. A dev_req seen with bus_grant low raises bus_req in the next cycle.
- R5: mem_addr, mem_rd, mem_wr and dev_ack are active only in a word cycle, which needs both bus_grant and dev_req high. mem_addr then equals the address register, and mem_addr is zero otherwise.
- R6: The to-memory bit set gives mem_wr strobes. The bit clear gives mem_rd strobes. Exactly one strobe is active per word.
- R7: Each word cycle adds one to the address register and subtracts one from the count register.
- R8: In burst tenure, bus_req stays high across consecutive words while dev_req stays high. If dev_req drops before the count is done, bus_req falls, and the transfer resumes when dev_req returns.
- R9: In cycle-steal tenure, bus_req falls after every single word.
- R10: The word that brings the count to zero deasserts bus_req and sets irq. irq holds until the mode word is written.
- R11: After dropping bus_req, the engine does not raise it again until bus_grant has been seen low.
- R12: Starting with a count of zero sets irq at once and never raises bus_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register port select |
| wr_en | input | 1 | Register write strobe |
| rsel | input | 2 | Register index |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data |
| bus_grant | input | 1 | Processor has released the bus |
| bus_req | output | 1 | Engine asks for the bus |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dev_req | input | 1 | Peripheral wants a word moved |
| dev_ack | output | 1 | Word cycle for the peripheral |
| irq | output | 1 | Block finished |

## Verification
The engine is driven with a peripheral request held steady through a burst, with a request that drops partway through a burst, and with cycle-steal tenure under a steady request. These three runs separate the burst and steal release paths by the number of bus tenures counted against the number of words moved. One steal run holds grant high after a release, which shows that the engine waits for grant to fall before it asks again. Further runs start with a zero count and attempt writes while grant is high. Together they show the zero-length shortcut and the register lockout, and each run checks the logged address sequence and the strobe type.

// File: rtl/dma_pkg.sv
// Shared encodings for the block transfer engine.
// Assumes register index and mode bit positions are fixed by the host software.
package dma_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_MODE  = 2'd2
    } reg_sel_e;

    localparam int MODE_START = 0;
    localparam int MODE_TOMEM = 1;
    localparam int MODE_BURST = 2;
    localparam int MODE_BUSY  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_REQ,
        ST_XFER,
        ST_REL
    } seq_state_e;

    typedef struct packed {
        logic burst;
        logic to_mem;
    } xfer_mode_t;

endpackage

// File: rtl/dma_regs.sv
// Host-visible registers: start address, remaining count, mode, and irq flag.
// Assumes host accesses happen only while bus_grant is low; the engine steps
// the address and count only while it holds the bus, so the two never collide.
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          wr_en,
    input  logic [1:0]    rsel,
    input  logic [DW-1:0] wdata,
    input  logic          bus_grant,
    input  logic          step,
    input  logic          finish,
    input  logic          busy,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output xfer_mode_t    mode_q,
    output logic          irq_q,
    output logic          go
);

    logic host_wr;
    logic mode_wr;
    logic cnt_is_zero;

    assign host_wr     = cs && wr_en && !bus_grant;
    assign mode_wr     = host_wr && (rsel == SEL_MODE);
    assign cnt_is_zero = (cnt_q == '0);
    assign go          = mode_wr && wdata[MODE_START] && !cnt_is_zero;

    // Register update: host loads, per-word stepping and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (step) begin
                addr_q <= addr_q + AW'(1);
                cnt_q  <= cnt_q - CW'(1);
            end
            if (finish) begin
                irq_q <= 1'b1;
            end
            if (host_wr) begin
                case (rsel)
                    SEL_ADDR:  addr_q <= wdata[AW-1:0];
                    SEL_COUNT: cnt_q  <= wdata[CW-1:0];
                    SEL_MODE: begin
                        mode_q.burst  <= wdata[MODE_BURST];
                        mode_q.to_mem <= wdata[MODE_TOMEM];
                        irq_q         <= wdata[MODE_START] && cnt_is_zero;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read mux: zero unless selected while the processor owns the bus.
    always_comb begin
        rdata = '0;
        if (cs && !bus_grant) begin
            case (rsel)
                SEL_ADDR:  rdata[AW-1:0] = addr_q;
                SEL_COUNT: rdata[CW-1:0] = cnt_q;
                SEL_MODE: begin
                    rdata[MODE_TOMEM] = mode_q.to_mem;
                    rdata[MODE_BURST] = mode_q.burst;
                    rdata[MODE_BUSY]  = busy;
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_seq.sv
// Bus tenure sequencer: arms on start, requests the bus on peripheral demand,
// moves one word per granted cycle and releases per the tenure mode.
// Assumes bus_grant follows bus_req from an external arbiter.
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bus_grant,
    input  logic dev_req,
    input  logic burst,
    input  logic last,
    input  logic cnt_zero,
    output logic bus_req,
    output logic xfer,
    output logic finish,
    output logic busy
);

    seq_state_e state_q, state_d;

    assign xfer    = (state_q == ST_XFER) && bus_grant && dev_req;
    assign finish  = xfer && last;
    assign bus_req = (state_q == ST_REQ) || (state_q == ST_XFER);
    assign busy    = (state_q != ST_IDLE);

    // Next-state selection for the tenure sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (go) state_d = ST_ARMED;
            ST_ARMED: if (dev_req && !bus_grant) state_d = ST_REQ;
            ST_REQ:   if (bus_grant) state_d = ST_XFER;
            ST_XFER:  if (!xfer || last || !burst) state_d = ST_REL;
            ST_REL:   if (!bus_grant) state_d = cnt_zero ? ST_IDLE : ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/dma_engine.sv
// Top of the block transfer engine: register port plus tenure sequencer.
// Assumes DW is at least AW, CW and 4; memory outputs are zero unless granted.
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          wr_en,
    input  logic [1:0]    rsel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic          dev_req,
    output logic          dev_ack,
    output logic          irq
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    xfer_mode_t    mode_q;
    logic          go;
    logic          xfer;
    logic          finish;
    logic          busy;
    logic          last;
    logic          cnt_zero;

    assign last     = (cnt_q == CW'(1));
    assign cnt_zero = (cnt_q == '0);

    dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .wr_en     (wr_en),
        .rsel      (rsel),
        .wdata     (wdata),
        .bus_grant (bus_grant),
        .step      (xfer),
        .finish    (finish),
        .busy      (busy),
        .rdata     (rdata),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .mode_q    (mode_q),
        .irq_q     (irq),
        .go        (go)
    );

    dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .bus_grant (bus_grant),
        .dev_req   (dev_req),
        .burst     (mode_q.burst),
        .last      (last),
        .cnt_zero  (cnt_zero),
        .bus_req   (bus_req),
        .xfer      (xfer),
        .finish    (finish),
        .busy      (busy)
    );

    assign mem_addr = xfer ? addr_q : '0;
    assign mem_rd   = xfer && !mode_q.to_mem;
    assign mem_wr   = xfer && mode_q.to_mem;
    assign dev_ack  = xfer;

endmodule

// File: rtl/dma_engine_chk.sv
// Temporal checks on the transfer engine, attached by bind.
// Assumes it sees the top's address, count and tenure-mode state.
module dma_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          wr_en,
    input logic [1:0]    rsel,
    input logic          bus_grant,
    input logic          bus_req,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          dev_ack,
    input logic          irq,
    input logic          burst_q,
    input logic [AW-1:0] addr_q,
    input logic [CW-1:0] cnt_q
);

    logic mode_write;
    assign mode_write = cs && wr_en && (rsel == 2'd2) && !bus_grant;

    a_r5_strobe_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || dev_ack) |-> (bus_grant && bus_req));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> $countones({mem_rd, mem_wr}) == 1);

    a_r7_addr_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> (addr_q == $past(addr_q) + AW'(1)) && (cnt_q == $past(cnt_q) - CW'(1)));

    a_r9_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && !burst_q) |=> !bus_req);

    a_r10_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && cnt_q == CW'(1)) |=> (irq && !bus_req));

    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mode_write) |=> irq);

    a_r11_wait_grant_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && bus_grant) |=> !bus_req);

    a_r12_request_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (cnt_q != '0));

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .wr_en     (wr_en),
    .rsel      (rsel),
    .bus_grant (bus_grant),
    .bus_req   (bus_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dev_ack   (dev_ack),
    .irq       (irq),
    .burst_q   (mode_q.burst),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q)
);

// File: tb/dma_engine_test.sv
// Directed bench: an arbiter that grants on request, a word logger, and one
// task per scenario.
`timescale 1ns/1ps
module dma_engine_test;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    rsel = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          bus_grant;
    logic          bus_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic          dev_req = 1'b0;
    logic          dev_ack;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;
    int nwords = 0;
    int tenures = 0;
    logic          grant_force = 1'b0;
    logic          exp_to_mem = 1'b0;
    logic [AW-1:0] wlog [64];
    logic          prev_br = 1'b0;
    logic          prev_bg = 1'b0;

    always #4 clk = ~clk;

    dma_engine #(.AW(AW), .CW(CW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rsel(rsel),
        .wdata(wdata), .rdata(rdata), .bus_grant(bus_grant), .bus_req(bus_req),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .dev_req(dev_req), .dev_ack(dev_ack), .irq(irq)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Arbiter model: grant follows request shortly after each rising edge.
    initial begin
        bus_grant = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            bus_grant = (bus_req && rst_n) || grant_force;
        end
    end

    // Word logger and tenure counter, sampled mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dev_ack) begin
                    if (nwords < 64) wlog[nwords] = mem_addr;
                    check("R5 grant during word", bus_grant, 1);
                    check("R6 strobe type", {mem_wr, mem_rd}, exp_to_mem ? 2'b10 : 2'b01);
                    nwords++;
                end else begin
                    if (mem_addr != '0 || mem_rd || mem_wr)
                        check("R5 idle memory outputs", {mem_addr, mem_rd, mem_wr}, 0);
                end
                if (bus_req && !prev_br) begin
                    tenures++;
                    if (prev_bg) check("R11 request while grant high", 1, 0);
                end
                prev_br = bus_req;
                prev_bg = bus_grant;
            end
        end
    end

    task automatic host_write(input logic [1:0] sel, input logic [DW-1:0] val);
        @(negedge clk);
        cs = 1'b1; wr_en = 1'b1; rsel = sel; wdata = val;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [DW-1:0] val);
        @(negedge clk);
        cs = 1'b1; rsel = sel;
        #1;
        val = rdata;
        cs = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 300) begin
            @(negedge clk);
            n++;
        end
        check({tag, " irq reached"}, irq, 1);
    endtask

    task automatic wait_words(input int target);
        int n = 0;
        while (nwords < target && n < 300) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        nwords = 0;
        tenures = 0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        @(negedge clk);
        check("R1 outputs after reset", {bus_req, mem_rd, mem_wr, dev_ack, irq}, 0);
        host_read(2'd0, v); check("R1 address reset", v, 0);
        host_read(2'd1, v); check("R1 count reset", v, 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] v;
        host_write(2'd0, 16'h0100);
        host_write(2'd1, 16'd5);
        host_write(2'd2, 16'h0006);
        host_read(2'd0, v); check("R2 address readback", v, 16'h0100);
        host_read(2'd1, v); check("R2 count readback", v, 5);
        host_read(2'd2, v); check("R2 mode readback", v, 16'h0006);
        check("R2 no request without start", bus_req, 0);
    endtask

    task automatic t_grant_lockout();
        logic [DW-1:0] v;
        grant_force = 1'b1;
        repeat (2) @(negedge clk);
        host_write(2'd0, 16'h0777);
        host_write(2'd2, 16'h0001);
        cs = 1'b1; rsel = 2'd1; #1;
        check("R3 read zero under grant", rdata, 0);
        cs = 1'b0;
        grant_force = 1'b0;
        dev_req = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 start ignored under grant", bus_req, 0);
        dev_req = 1'b0;
        host_read(2'd0, v); check("R3 address write ignored", v, 16'h0100);
        host_read(2'd2, v); check("R3 mode not busy", v[3], 0);
    endtask

    task automatic t_burst();
        logic [DW-1:0] v;
        int bad = 0;
        clear_log();
        exp_to_mem = 1'b1;
        host_write(2'd0, 16'h0200);
        host_write(2'd1, 16'd4);
        host_write(2'd2, 16'h0007);
        repeat (5) @(negedge clk);
        check("R4 no request before dev_req", bus_req, 0);
        dev_req = 1'b1;
        @(negedge clk);
        check("R4 request one cycle after dev_req", bus_req, 1);
        wait_irq("R10 burst");
        dev_req = 1'b0;
        check("R8 burst word count", nwords, 4);
        check("R8 burst single tenure", tenures, 1);
        for (int i = 0; i < 4; i++) if (wlog[i] != 16'h0200 + i[15:0]) bad++;
        check("R7 burst address sequence", bad, 0);
        repeat (3) @(negedge clk);
        check("R10 request dropped at end", bus_req, 0);
        host_read(2'd1, v); check("R7 count at zero", v, 0);
        host_read(2'd0, v); check("R7 address past block", v, 16'h0204);
        repeat (4) @(negedge clk);
        check("R10 irq holds", irq, 1);
        host_write(2'd2, 16'h0000);
        check("R10 irq cleared by mode write", irq, 0);
    endtask

    task automatic t_burst_pause();
        logic [DW-1:0] v;
        int bad = 0;
        clear_log();
        exp_to_mem = 1'b0;
        host_write(2'd0, 16'h0300);
        host_write(2'd1, 16'd6);
        host_write(2'd2, 16'h0005);
        dev_req = 1'b1;
        wait_words(2);
        @(posedge clk);
        #1 dev_req = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 paused word count", nwords, 2);
        check("R8 paused request dropped", bus_req, 0);
        check("R8 paused no irq", irq, 0);
        host_read(2'd1, v); check("R7 remaining count mid-block", v, 4);
        dev_req = 1'b1;
        wait_irq("R8 resumed");
        dev_req = 1'b0;
        check("R8 resumed total words", nwords, 6);
        check("R8 resumed two tenures", tenures, 2);
        for (int i = 0; i < 6; i++) if (wlog[i] != 16'h0300 + i[15:0]) bad++;
        check("R6 read-direction address sequence", bad, 0);
        host_write(2'd2, 16'h0000);
    endtask

    task automatic t_steal();
        clear_log();
        exp_to_mem = 1'b1;
        host_write(2'd0, 16'h0400);
        host_write(2'd1, 16'd3);
        host_write(2'd2, 16'h0003);
        dev_req = 1'b1;
        wait_words(1);
        grant_force = 1'b1;
        repeat (8) @(negedge clk);
        check("R11 held grant blocks new request", bus_req, 0);
        check("R9 one word per tenure", nwords, 1);
        grant_force = 1'b0;
        wait_irq("R9 steal");
        dev_req = 1'b0;
        check("R9 steal word count", nwords, 3);
        check("R9 steal tenure per word", tenures, 3);
        check("R9 steal last address", wlog[2], 16'h0402);
        host_write(2'd2, 16'h0000);
    endtask

    task automatic t_zero();
        logic [DW-1:0] v;
        clear_log();
        host_write(2'd1, 16'd0);
        dev_req = 1'b1;
        host_write(2'd2, 16'h0005);
        check("R12 zero count irq", irq, 1);
        repeat (5) @(negedge clk);
        check("R12 zero count no request", tenures, 0);
        check("R12 zero count no words", nwords, 0);
        host_read(2'd2, v); check("R12 zero count not busy", v[3], 0);
        dev_req = 1'b0;
        host_write(2'd2, 16'h0000);
        check("R10 irq cleared after zero start", irq, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_grant_lockout();
        t_burst();
        t_burst_pause();
        t_steal();
        t_zero();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule